// File: doc/BRIEF.md
# Sign-Magnitude Add/Compare Unit

This unit carries out the additive instructions of a word-oriented processor whose words are a sign bit and a 30-bit magnitude. The operations are add, subtract, the four forms of index modify (increment, decrement, enter, enter-negative) and compare. The register word, a second operand and the instruction sign are presented with a pulse on `start_i`. One clock later the unit returns the new register word with `done_o`, pulses `ovf_set_o` if the magnitude did not fit, and, for a compare, latches one of three comparison flags.

Internally both operands become two's complement, go through one adder and come back to sign-magnitude. Minus zero is a real value. A zero result takes the register's old sign for add, subtract, increment and decrement, and takes the instruction sign for enter and enter-negative. Compare treats the two zeros as equal. Field extraction, memory access and clearing of the overflow flag are done by neighbouring logic.

Top module: `sm_addcmp_unit`

## Requirements
- R1: Word layout is bit 30 = sign (1 = negative) and bits 29:0 = magnitude. With op_i = 0 (add), result_o is the sign-magnitude value of reg_i + opnd_i.
- R2: With op_i = 1 (subtract), result_o is the sign-magnitude value of reg_i - opnd_i.
- R3: When the true result magnitude is 2^30 or more, result_o keeps only its low 30 bits and ovf_set_o is 1 for exactly the one cycle in which done_o is 1. Otherwise ovf_set_o is 0.
- R4: For add and subtract, a result whose kept magnitude is zero carries the sign of reg_i.
- R5: With op_i = 2 (modify), f_i selects the operation: f_i = 0 gives reg_i + opnd_i, f_i = 1 gives reg_i - opnd_i, f_i = 2 gives opnd_i, and f_i = 3 gives -opnd_i.
- R6: For a modify whose kept magnitude is zero, f_i = 0 and f_i = 1 keep the sign of reg_i, and f_i = 2 and f_i = 3 take isgn_i.
- R7: A modify with f_i from 4 to 7 is illegal. result_o returns reg_i unchanged and ovf_set_o stays 0.
- R8: With op_i = 3 (compare), reg_i - opnd_i sets exactly one of cmp_lt_o, cmp_eq_o and cmp_gt_o (negative, zero or positive difference), and result_o returns reg_i unchanged.
- R9: Plus zero and minus zero compare as equal in either order.
- R10: The comparison flags change only when a compare completes. Other operations leave them as they were.
- R11: done_o is high exactly one cycle after each cycle in which start_i is high. While start_i is low, result_o holds its value.
- R12: After reset, result_o is plus zero, and done_o, ovf_set_o and all three comparison flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch one operation this cycle |
| op_i | input | 2 | 0 add, 1 subtract, 2 modify, 3 compare |
| f_i | input | 3 | Modify selector (0 inc, 1 dec, 2 enter, 3 enter-negative) |
| isgn_i | input | 1 | Sign of the instruction, used for a zero enter result |
| reg_i | input | MAG_W+1 | Register operand, sign-magnitude |
| opnd_i | input | MAG_W+1 | Second operand, sign-magnitude |
| result_o | output | MAG_W+1 | New register word |
| ovf_set_o | output | 1 | One-cycle request to set the overflow flag |
| cmp_lt_o | output | 1 | Register was less than operand at last compare |
| cmp_eq_o | output | 1 | Register equalled operand at last compare |
| cmp_gt_o | output | 1 | Register was greater than operand at last compare |
| done_o | output | 1 | Result valid, one cycle after start |

## Verification
The bench builds the unit with MAG_W = 30 and ADDER_KIND = 1. That selects the explicit ripple-carry adder, so its per-bit carry chain is what carries the arithmetic. With a 30-bit magnitude, the operand 2^30-1 lies at the exact edge of the format, and the bench uses it to reach both overflow that truncates to zero and the largest sum, 2^31-2. The sign of a zero result is checked under every operation and every legal modify selector, which makes the operation-dependent zero-sign rule and the equality of plus and minus zero visible at the ports.

// File: rtl/sm_addcmp_pkg.sv
package sm_addcmp_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_MOD = 2'd2,
      OP_CMP = 2'd3
   } sm_op_e;

   localparam logic [2:0] MF_INC = 3'd0;
   localparam logic [2:0] MF_DEC = 3'd1;
   localparam logic [2:0] MF_ENT = 3'd2;
   localparam logic [2:0] MF_ENN = 3'd3;
endpackage

// File: rtl/sm_addcmp_sm2tc.sv
// Sign-magnitude to two's complement with an optional negation.
module sm_addcmp_sm2tc #(
   parameter int MAG_W = 30,
   parameter int TW    = MAG_W + 2
) (
   input  logic             sign_i,
   input  logic [MAG_W-1:0] mag_i,
   input  logic             neg_i,
   output logic [TW-1:0]    tc_o
);
   logic [TW-1:0] ext;

   always_comb begin
      ext = {{(TW-MAG_W){1'b0}}, mag_i};
      if (sign_i ^ neg_i)
         tc_o = ~ext + TW'(1);
      else
         tc_o = ext;
   end
endmodule

// File: rtl/sm_addcmp_adder.sv
// Two's complement adder; ADDER_KIND 0 = inferred, 1 = explicit ripple chain.
module sm_addcmp_adder #(
   parameter int TW         = 32,
   parameter int ADDER_KIND = 0
) (
   input  logic [TW-1:0] a_i,
   input  logic [TW-1:0] b_i,
   output logic [TW-1:0] sum_o
);
   generate
      if (ADDER_KIND == 0) begin : g_infer
         assign sum_o = a_i + b_i;
      end else begin : g_ripple
         logic [TW-1:0] cy;
         assign cy[0] = 1'b0;
         for (genvar i = 0; i < TW; i++) begin : g_bit
            assign sum_o[i] = a_i[i] ^ b_i[i] ^ cy[i];
            if (i < TW - 1) begin : g_cy
               assign cy[i+1] = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sm_addcmp_tc2sm.sv
// Two's complement sum back to sign-magnitude with truncation and zero-sign rule.
module sm_addcmp_tc2sm #(
   parameter int MAG_W = 30,
   parameter int TW    = MAG_W + 2
) (
   input  logic [TW-1:0]    sum_i,
   input  logic             zsign_i,
   output logic [MAG_W-1:0] mag_o,
   output logic             sign_o,
   output logic             ovf_o
);
   logic [TW-1:0] absv;

   always_comb begin
      if (sum_i[TW-1])
         absv = ~sum_i + TW'(1);
      else
         absv = sum_i;
      mag_o  = absv[MAG_W-1:0];
      ovf_o  = |absv[TW-1:MAG_W];
      sign_o = (mag_o == '0) ? zsign_i : sum_i[TW-1];
   end
endmodule

// File: rtl/sm_addcmp_unit.sv
module sm_addcmp_unit #(
   parameter int MAG_W      = 30,
   parameter int ADDER_KIND = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [1:0]       op_i,
   input  logic [2:0]       f_i,
   input  logic             isgn_i,
   input  logic [MAG_W:0]   reg_i,
   input  logic [MAG_W:0]   opnd_i,
   output logic [MAG_W:0]   result_o,
   output logic             ovf_set_o,
   output logic             cmp_lt_o,
   output logic             cmp_eq_o,
   output logic             cmp_gt_o,
   output logic             done_o
);
   import sm_addcmp_pkg::*;

   localparam int TW = MAG_W + 2;

   generate
      if (MAG_W < 2) begin : g_bad_width
         $error("sm_addcmp_unit: MAG_W must be at least 2");
      end
      if (ADDER_KIND < 0 || ADDER_KIND > 1) begin : g_bad_kind
         $error("sm_addcmp_unit: ADDER_KIND must be 0 or 1");
      end
   endgenerate

   sm_op_e op;
   logic   use_reg, neg_b, zsign, illegal, is_cmp;

   assign op = sm_op_e'(op_i);

   always_comb begin
      use_reg = 1'b1;
      neg_b   = 1'b0;
      zsign   = reg_i[MAG_W];
      illegal = 1'b0;
      is_cmp  = 1'b0;
      unique case (op)
         OP_ADD: ;
         OP_SUB: neg_b = 1'b1;
         OP_MOD: begin
            unique case (f_i)
               MF_INC: ;
               MF_DEC: neg_b = 1'b1;
               MF_ENT: begin
                  use_reg = 1'b0;
                  zsign   = isgn_i;
               end
               MF_ENN: begin
                  use_reg = 1'b0;
                  neg_b   = 1'b1;
                  zsign   = isgn_i;
               end
               default: illegal = 1'b1;
            endcase
         end
         OP_CMP: begin
            neg_b  = 1'b1;
            is_cmp = 1'b1;
         end
         default: ;
      endcase
   end

   logic [TW-1:0]    a_tc, b_tc, sum_tc;
   logic [MAG_W-1:0] res_mag;
   logic             res_sign, res_ovf;

   sm_addcmp_sm2tc #(.MAG_W(MAG_W), .TW(TW)) u_cvt_a (
      .sign_i (reg_i[MAG_W] & use_reg),
      .mag_i  (reg_i[MAG_W-1:0] & {MAG_W{use_reg}}),
      .neg_i  (1'b0),
      .tc_o   (a_tc)
   );

   sm_addcmp_sm2tc #(.MAG_W(MAG_W), .TW(TW)) u_cvt_b (
      .sign_i (opnd_i[MAG_W]),
      .mag_i  (opnd_i[MAG_W-1:0]),
      .neg_i  (neg_b),
      .tc_o   (b_tc)
   );

   sm_addcmp_adder #(.TW(TW), .ADDER_KIND(ADDER_KIND)) u_add (
      .a_i   (a_tc),
      .b_i   (b_tc),
      .sum_o (sum_tc)
   );

   sm_addcmp_tc2sm #(.MAG_W(MAG_W), .TW(TW)) u_back (
      .sum_i   (sum_tc),
      .zsign_i (zsign),
      .mag_o   (res_mag),
      .sign_o  (res_sign),
      .ovf_o   (res_ovf)
   );

   logic diff_neg, diff_zero;
   assign diff_neg  = sum_tc[TW-1];
   assign diff_zero = (sum_tc == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o  <= '0;
         ovf_set_o <= 1'b0;
         cmp_lt_o  <= 1'b0;
         cmp_eq_o  <= 1'b0;
         cmp_gt_o  <= 1'b0;
         done_o    <= 1'b0;
      end else begin
         done_o    <= start_i;
         ovf_set_o <= 1'b0;
         if (start_i) begin
            if (illegal || is_cmp) begin
               result_o <= reg_i;
            end else begin
               result_o  <= {res_sign, res_mag};
               ovf_set_o <= res_ovf;
            end
            if (is_cmp) begin
               cmp_lt_o <= diff_neg;
               cmp_eq_o <= diff_zero;
               cmp_gt_o <= !diff_neg && !diff_zero;
            end
         end
      end
   end
endmodule

// File: rtl/sm_addcmp_unit_chk.sv
module sm_addcmp_unit_chk #(
   parameter int MAG_W = 30
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [1:0]       op_i,
   input logic [2:0]       f_i,
   input logic             isgn_i,
   input logic [MAG_W:0]   reg_i,
   input logic [MAG_W:0]   opnd_i,
   input logic [MAG_W:0]   result_o,
   input logic             ovf_set_o,
   input logic             cmp_lt_o,
   input logic             cmp_eq_o,
   input logic             cmp_gt_o,
   input logic             done_o
);
   logic pv;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pv <= 1'b0;
      else        pv <= 1'b1;
   end

   // R11
   done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pv |-> (done_o == $past(start_i)));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && !$past(start_i)) |-> ($stable(result_o) && !ovf_set_o));

   // R3
   ovf_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_set_o |-> done_o);

   // R8
   flags_onehot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmp_lt_o, cmp_eq_o, cmp_gt_o}));

   // R8
   cmp_one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && done_o && $past(op_i) == 2'd3) |->
         ($countones({cmp_lt_o, cmp_eq_o, cmp_gt_o}) == 1 && result_o == $past(reg_i)));

   // R9
   zeros_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && done_o && $past(op_i) == 2'd3 && $past(reg_i[MAG_W-1:0]) == '0
          && $past(opnd_i[MAG_W-1:0]) == '0) |-> cmp_eq_o);

   // R10
   flags_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && !($past(start_i) && $past(op_i) == 2'd3)) |->
         $stable({cmp_lt_o, cmp_eq_o, cmp_gt_o}));

   // R4
   addsub_zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && done_o && $past(op_i) < 2'd2 && result_o[MAG_W-1:0] == '0) |->
         (result_o[MAG_W] == $past(reg_i[MAG_W])));

   // R6
   enter_zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && done_o && $past(op_i) == 2'd2 && ($past(f_i) == 3'd2 || $past(f_i) == 3'd3)
          && result_o[MAG_W-1:0] == '0) |-> (result_o[MAG_W] == $past(isgn_i)));

   // R7
   illegal_f_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && done_o && $past(op_i) == 2'd2 && $past(f_i) > 3'd3) |->
         (result_o == $past(reg_i) && !ovf_set_o));
endmodule

bind sm_addcmp_unit sm_addcmp_unit_chk #(.MAG_W(MAG_W)) chk_i (.*);

// File: tb/sm_addcmp_unit_tb.sv
module sm_addcmp_unit_tb_top;
   localparam int MW = 30;
   localparam int WW = MW + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [1:0]    op_i = '0;
   logic [2:0]    f_i = '0;
   logic          isgn_i = 1'b0;
   logic [WW-1:0] reg_i = '0;
   logic [WW-1:0] opnd_i = '0;
   logic [WW-1:0] result_o;
   logic          ovf_set_o, cmp_lt_o, cmp_eq_o, cmp_gt_o, done_o;

   always #10 clk = ~clk;

   sm_addcmp_unit #(.MAG_W(MW), .ADDER_KIND(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .f_i(f_i),
      .isgn_i(isgn_i), .reg_i(reg_i), .opnd_i(opnd_i), .result_o(result_o),
      .ovf_set_o(ovf_set_o), .cmp_lt_o(cmp_lt_o), .cmp_eq_o(cmp_eq_o),
      .cmp_gt_o(cmp_gt_o), .done_o(done_o)
   );

   function automatic logic [WW-1:0] P(int n);
      return {1'b0, MW'(n)};
   endfunction
   function automatic logic [WW-1:0] N(int n);
      return {1'b1, MW'(n)};
   endfunction

   localparam logic [WW-1:0] PM = {1'b0, 30'h3FFF_FFFF};
   localparam logic [WW-1:0] NM = {1'b1, 30'h3FFF_FFFF};

   typedef struct packed {
      logic [1:0]    op;
      logic [2:0]    f;
      logic          isg;
      logic [WW-1:0] rg;
      logic [WW-1:0] od;
      logic [WW-1:0] res;
      logic          ovf;
      logic [2:0]    flg;  // {lt, eq, gt}, checked on compare rows only
      logic [3:0]    rq;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 3'd0, 1'b0, P(5),  P(7),  P(12), 1'b0, 3'b000, 4'd1}, // R1
      '{2'd0, 3'd0, 1'b0, P(5),  N(7),  N(2),  1'b0, 3'b000, 4'd1}, // R1
      '{2'd0, 3'd0, 1'b0, N(5),  P(5),  N(0),  1'b0, 3'b000, 4'd4}, // R4
      '{2'd0, 3'd0, 1'b0, P(5),  N(5),  P(0),  1'b0, 3'b000, 4'd4}, // R4
      '{2'd1, 3'd0, 1'b0, P(3),  P(10), N(7),  1'b0, 3'b000, 4'd2}, // R2
      '{2'd1, 3'd0, 1'b0, N(4),  N(4),  N(0),  1'b0, 3'b000, 4'd4}, // R4
      '{2'd0, 3'd0, 1'b0, PM,    P(1),  P(0),  1'b1, 3'b000, 4'd3}, // R3
      '{2'd0, 3'd0, 1'b0, NM,    N(3),  N(2),  1'b1, 3'b000, 4'd3}, // R3
      '{2'd2, 3'd0, 1'b0, P(10), N(3),  P(7),  1'b0, 3'b000, 4'd5}, // R5
      '{2'd2, 3'd1, 1'b0, N(10), N(10), N(0),  1'b0, 3'b000, 4'd6}, // R6
      '{2'd2, 3'd2, 1'b1, P(4),  P(0),  N(0),  1'b0, 3'b000, 4'd6}, // R6
      '{2'd2, 3'd3, 1'b0, N(4),  P(0),  P(0),  1'b0, 3'b000, 4'd6}, // R6
      '{2'd2, 3'd3, 1'b1, P(4),  P(9),  N(9),  1'b0, 3'b000, 4'd5}, // R5
      '{2'd2, 3'd2, 1'b0, P(4),  N(8),  N(8),  1'b0, 3'b000, 4'd5}, // R5
      '{2'd2, 3'd5, 1'b0, N(33), P(1),  N(33), 1'b0, 3'b000, 4'd7}, // R7
      '{2'd2, 3'd0, 1'b0, PM,    PM,    {1'b0, 30'h3FFF_FFFE}, 1'b1, 3'b000, 4'd3}, // R3
      '{2'd3, 3'd0, 1'b0, P(5),  P(3),  P(5),  1'b0, 3'b001, 4'd8}, // R8
      '{2'd3, 3'd0, 1'b0, N(5),  P(3),  N(5),  1'b0, 3'b100, 4'd8}, // R8
      '{2'd3, 3'd0, 1'b0, P(0),  N(0),  P(0),  1'b0, 3'b010, 4'd9}, // R9
      '{2'd3, 3'd0, 1'b0, N(0),  P(0),  N(0),  1'b0, 3'b010, 4'd9}, // R9
      '{2'd3, 3'd0, 1'b0, N(7),  N(7),  N(7),  1'b0, 3'b010, 4'd8}, // R8
      '{2'd3, 3'd0, 1'b0, N(2),  N(9),  N(2),  1'b0, 3'b001, 4'd8}  // R8
   };

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic run_op(input logic [1:0] op, input logic [2:0] f, input logic isg,
                         input logic [WW-1:0] rg, input logic [WW-1:0] od);
      @(negedge clk);
      op_i = op; f_i = f; isgn_i = isg; reg_i = rg; opnd_i = od; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [WW-1:0] held;
      repeat (3) @(negedge clk);
      // R12 reset state
      check(result_o == '0 && !done_o && !ovf_set_o, "R12", {result_o, done_o, ovf_set_o}, 0);
      check({cmp_lt_o, cmp_eq_o, cmp_gt_o} == 3'b000, "R12", {cmp_lt_o, cmp_eq_o, cmp_gt_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d", VEC[i].rq);
         run_op(VEC[i].op, VEC[i].f, VEC[i].isg, VEC[i].rg, VEC[i].od);
         check(result_o == VEC[i].res, tag, result_o, VEC[i].res);
         check(ovf_set_o == VEC[i].ovf, tag, ovf_set_o, VEC[i].ovf);
         if (VEC[i].op == 2'd3)
            check({cmp_lt_o, cmp_eq_o, cmp_gt_o} == VEC[i].flg, tag,
                  {cmp_lt_o, cmp_eq_o, cmp_gt_o}, VEC[i].flg);
      end

      // R11 done one cycle after start, then drops
      run_op(2'd0, 3'd0, 1'b0, P(1), P(2));
      check(done_o == 1'b1, "R11", done_o, 1);
      held = result_o;
      op_i = 2'd1; reg_i = P(100); opnd_i = P(1);
      @(negedge clk);
      check(done_o == 1'b0, "R11", done_o, 0);
      check(result_o == held, "R11", result_o, held);

      // R3 overflow pulse lasts a single cycle
      run_op(2'd0, 3'd0, 1'b0, PM, P(2));
      check(ovf_set_o == 1'b1 && result_o == P(1), "R3", {ovf_set_o, result_o}, {1'b1, P(1)});
      @(negedge clk);
      check(ovf_set_o == 1'b0, "R3", ovf_set_o, 0);

      // R10 flags survive a non-compare operation
      run_op(2'd3, 3'd0, 1'b0, N(5), P(3));
      check({cmp_lt_o, cmp_eq_o, cmp_gt_o} == 3'b100, "R10", {cmp_lt_o, cmp_eq_o, cmp_gt_o}, 3'b100);
      run_op(2'd0, 3'd0, 1'b0, P(8), P(8));
      check(result_o == P(16), "R10", result_o, P(16));
      check({cmp_lt_o, cmp_eq_o, cmp_gt_o} == 3'b100, "R10", {cmp_lt_o, cmp_eq_o, cmp_gt_o}, 3'b100);

      // R7 top illegal selector with an operand that would overflow
      run_op(2'd2, 3'd7, 1'b1, PM, PM);
      check(result_o == PM && !ovf_set_o, "R7", {ovf_set_o, result_o}, {1'b0, PM});

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule